// File: doc/BRIEF.md
# Run-level coefficient word packer

This block sits behind a variable-length decoder. It turns each decoded DCT coefficient event into one 32-bit word for a coefficient buffer in memory. Ordinary coefficients arrive as run/level pairs on a valid/ready stream. The intra DC term arrives on the same stream, flagged as DC, with a bit count and the raw DC bits. A single-cycle block-end strobe closes each block. The packer holds one outgoing word in a register and can hold one pending terminator. It stalls the coefficient stream whenever either of these is occupied.

An ordinary coefficient becomes a word with the run in the upper half and the signed level in the lower half. The DC term becomes a word that carries its bit count in the upper half. Its lower half holds the DC bits pushed up against the most significant end, with zeros below them. Every block end produces a terminator word that a downstream parser recognises by the run value 0xff. This holds even when the block carried no coefficients.

Top module: `rlc_word_packer`

## Requirements
- R1: An accepted coefficient with `cf_is_dc`=0 yields the word {cf_run, cf_level}: run in bits 31:16, the two's-complement level unchanged in bits 15:0.
- R2: An accepted coefficient with `cf_is_dc`=1 yields a word whose bits 31:16 hold `cf_dc_size` zero-extended; the size is limited to 0..11.
- R3: In a DC word, the low `cf_dc_size` bits of `cf_dc_raw` occupy the top `cf_dc_size` bits of bits 15:0 in the same order; raw bits at or above position `cf_dc_size` have no effect on the word.
- R4: In a DC word, the bits of 15:0 below the DC bits are zero, so a size of 0 gives 16'h0000 in bits 15:0.
- R5: A `blk_end` pulse yields exactly one terminator word 32'h00FF_0000, emitted after every coefficient accepted before it or in the same cycle, and before any coefficient accepted later.
- R6: A `blk_end` pulse with no coefficient since the previous terminator still yields exactly one terminator word.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` is unchanged on the next cycle; every accepted event leaves exactly once, in acceptance order.
- R8: `cf_ready` is low while a terminator is pending, and while a word is held that the sink has not taken.
- R9: After a synchronous active-low reset, `out_valid` is low, no terminator is pending and `cf_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cf_valid | input | 1 | Coefficient event offered |
| cf_ready | output | 1 | Packer takes the event this cycle |
| cf_is_dc | input | 1 | 1: intra DC event, 0: run/level pair |
| cf_run | input | 16 | Zero run preceding the coefficient |
| cf_level | input | 16 | Signed coefficient level |
| cf_dc_size | input | 4 | Number of DC bits, 0..11 |
| cf_dc_raw | input | 11 | DC bits, right-aligned |
| blk_end | input | 1 | One-cycle block-end strobe |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Sink takes the word this cycle |
| out_word | output | 32 | Packed coefficient or terminator word |

## Verification
Every DC size from 0 to 11 is swept with raw patterns that carry set bits above the size. A shift or mask that is off by one would leak those bits into the word or shift the value one position out of place. Empty blocks and a block end in the same cycle as a coefficient are driven to catch a lost or misordered terminator. Random sink back-pressure and a held-off sink check that a stalled word neither changes nor repeats, and that intake closes when the slot is full.

// File: rtl/rlc_pkg.sv
// Shared constants for the run-level coefficient word packer.
// Assumes a 16-bit field on each half of the 32-bit output word.
package rlc_pkg;
    localparam int FIELD_W  = 16;
    localparam int DC_MAX   = 11;
    localparam int TERM_RUN = 'hff;

    // Terminator word: sentinel run in the upper field, zero level.
    function automatic logic [2*FIELD_W-1:0] term_word();
        return {FIELD_W'(TERM_RUN), {FIELD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/rlc_dc_align.sv
// Left-justifies a right-aligned DC value of 'size' bits inside a field.
// Raw bits at or above 'size' are masked away; lower bits are zero-filled.
// Assumes size <= DC_MAX and FIELD_W >= DC_MAX.
module rlc_dc_align #(
    parameter int FIELD_W = 16,
    parameter int DC_MAX  = 11,
    localparam int SIZE_W = $clog2(DC_MAX + 1)
) (
    input  logic [SIZE_W-1:0]  size,
    input  logic [DC_MAX-1:0]  raw,
    output logic [FIELD_W-1:0] aligned
);
    logic [DC_MAX-1:0]  keep_mask;
    logic [DC_MAX-1:0]  kept;
    logic [FIELD_W-1:0] widened;

    // Keep only the low 'size' bits and push them to the top of the field.
    always_comb begin
        keep_mask = ~({DC_MAX{1'b1}} << size);
        kept      = raw & keep_mask;
        widened   = FIELD_W'(kept);
        aligned   = widened << (FIELD_W - int'(size));
    end
endmodule

// File: rtl/rlc_word_format.sv
// Builds the 32-bit word for one coefficient event: a run/level pair or
// a DC word with its size field and left-justified value. Pure logic.
module rlc_word_format #(
    parameter int FIELD_W = 16,
    parameter int DC_MAX  = 11,
    localparam int SIZE_W = $clog2(DC_MAX + 1)
) (
    input  logic                 is_dc,
    input  logic [FIELD_W-1:0]   run,
    input  logic [FIELD_W-1:0]   level,
    input  logic [SIZE_W-1:0]    dc_size,
    input  logic [DC_MAX-1:0]    dc_raw,
    output logic [2*FIELD_W-1:0] word
);
    logic [FIELD_W-1:0] dc_value;

    rlc_dc_align #(.FIELD_W(FIELD_W), .DC_MAX(DC_MAX)) u_align (
        .size    (dc_size),
        .raw     (dc_raw),
        .aligned (dc_value)
    );

    // Select the word layout for the event kind.
    always_comb begin
        if (is_dc)
            word = {FIELD_W'(dc_size), dc_value};
        else
            word = {run, level};
    end
endmodule

// File: rtl/rlc_out_slot.sv
// One-word output register with a single pending-terminator flag.
// A pending terminator has priority over new intake and blocks it, so it
// lands behind every word already accepted. Assumes no second block-end
// strobe arrives while a terminator is pending and the slot is stalled.
module rlc_out_slot #(
    parameter int WORD_W = 32,
    parameter logic [WORD_W-1:0] TERM = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              blk_end,
    output logic              term_pending,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    logic slot_free;

    // The slot can load when empty or when its word leaves this cycle.
    always_comb begin
        slot_free = !out_valid || out_ready;
        in_ready  = slot_free && !term_pending;
    end

    // Load the terminator first, else an offered coefficient, else go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (slot_free) begin
            if (term_pending) begin
                out_valid <= 1'b1;
                out_word  <= TERM;
            end else if (in_valid) begin
                out_valid <= 1'b1;
                out_word  <= in_word;
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    // Remember a block end until its terminator has been loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            term_pending <= 1'b0;
        else
            term_pending <= blk_end || (term_pending && !slot_free);
    end
endmodule

// File: rtl/rlc_word_packer.sv
// Top: packs decoded coefficient events into 32-bit buffer words and
// appends a terminator word at every block end. Single clock, synchronous
// active-low reset. Assumes cf_dc_size <= DC_MAX on DC events.
module rlc_word_packer #(
    parameter int FIELD_W  = rlc_pkg::FIELD_W,
    parameter int DC_MAX   = rlc_pkg::DC_MAX,
    localparam int SIZE_W  = $clog2(DC_MAX + 1),
    localparam int WORD_W  = 2 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cf_valid,
    output logic              cf_ready,
    input  logic              cf_is_dc,
    input  logic [FIELD_W-1:0] cf_run,
    input  logic [FIELD_W-1:0] cf_level,
    input  logic [SIZE_W-1:0] cf_dc_size,
    input  logic [DC_MAX-1:0] cf_dc_raw,
    input  logic              blk_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam logic [WORD_W-1:0] TERM_WORD =
        {FIELD_W'(rlc_pkg::TERM_RUN), {FIELD_W{1'b0}}};

    logic [WORD_W-1:0] coef_word;
    logic              term_pending;

    rlc_word_format #(.FIELD_W(FIELD_W), .DC_MAX(DC_MAX)) u_format (
        .is_dc   (cf_is_dc),
        .run     (cf_run),
        .level   (cf_level),
        .dc_size (cf_dc_size),
        .dc_raw  (cf_dc_raw),
        .word    (coef_word)
    );

    rlc_out_slot #(.WORD_W(WORD_W), .TERM(TERM_WORD)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (cf_valid),
        .in_ready     (cf_ready),
        .in_word      (coef_word),
        .blk_end      (blk_end),
        .term_pending (term_pending),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_word     (out_word)
    );
endmodule

// File: rtl/rlc_word_packer_chk.sv
// Property checker for rlc_word_packer, attached by bind below.
// Observes ports and the internal pending-terminator flag only.
module rlc_word_packer_chk #(
    parameter int FIELD_W = 16,
    parameter int DC_MAX  = 11,
    localparam int SIZE_W = $clog2(DC_MAX + 1),
    localparam int WORD_W = 2 * FIELD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cf_valid,
    input logic              cf_ready,
    input logic              cf_is_dc,
    input logic [SIZE_W-1:0] cf_dc_size,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic              term_pending
);
    logic was_rst;

    // Flag the first cycle after reset has been applied.
    always_ff @(posedge clk) was_rst <= !rst_n;

    a_r2_dc_size_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_valid && cf_is_dc) |-> (int'(cf_dc_size) <= DC_MAX));

    a_r5_term_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_pending) |-> (out_valid && out_word[WORD_W-1:FIELD_W] == FIELD_W'('hff)
                                 && out_word[FIELD_W-1:0] == '0));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    a_r8_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        term_pending |-> !cf_ready);

    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !cf_ready);

    a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!out_valid && !term_pending && cf_ready));
endmodule

bind rlc_word_packer rlc_word_packer_chk #(.FIELD_W(FIELD_W), .DC_MAX(DC_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cf_valid     (cf_valid),
    .cf_ready     (cf_ready),
    .cf_is_dc     (cf_is_dc),
    .cf_dc_size   (cf_dc_size),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_word     (out_word),
    .term_pending (term_pending)
);

// File: tb/rlc_word_packer_test.sv
module rlc_word_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cf_valid = 1'b0;
    logic        cf_ready;
    logic        cf_is_dc = 1'b0;
    logic [15:0] cf_run = '0;
    logic [15:0] cf_level = '0;
    logic [3:0]  cf_dc_size = '0;
    logic [10:0] cf_dc_raw = '0;
    logic        blk_end = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    localparam logic [31:0] TERM = 32'h00FF_0000;

    int checks = 0;
    int failures = 0;
    int sink_mode = 0;      // 0: always ready, 1: pseudo-random, 2: held low
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    rlc_word_packer uut (
        .clk(clk), .rst_n(rst_n), .cf_valid(cf_valid), .cf_ready(cf_ready),
        .cf_is_dc(cf_is_dc), .cf_run(cf_run), .cf_level(cf_level),
        .cf_dc_size(cf_dc_size), .cf_dc_raw(cf_dc_raw), .blk_end(blk_end),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dc_exp(input int size, input int raw);
        int v;
        v = (size == 0) ? 0 : ((raw % (1 << size)) << (16 - size));
        return {16'(size), 16'(v)};
    endfunction

    // Sink side: set out_ready at the falling edge, then score the word
    // that will be taken at the next rising edge.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (sink_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk("R7 extra word", out_word, 32'hxxxx_xxxx);
            end else begin
                chk(tag_q.pop_front(), out_word, exp_q.pop_front());
            end
        end
    end

    // Offer one event; optionally strobe block end in the accepting cycle.
    task automatic put(input bit dc, input int run, input int lvl, input int size,
                       input int raw, input bit with_end, input string tag);
        @(negedge clk); #1;
        cf_valid = 1'b1; cf_is_dc = dc; cf_run = 16'(run); cf_level = 16'(lvl);
        cf_dc_size = 4'(size); cf_dc_raw = 11'(raw);
        while (!cf_ready) begin @(negedge clk); #1; end
        blk_end = with_end;
        exp_q.push_back(dc ? dc_exp(size, raw) : {16'(run), 16'(lvl)});
        tag_q.push_back(tag);
        if (with_end) begin exp_q.push_back(TERM); tag_q.push_back("R5 same-cycle end"); end
        @(negedge clk); #1;
        cf_valid = 1'b0; blk_end = 1'b0;
    endtask

    task automatic end_block(input string tag);
        @(negedge clk); #1;
        while (!cf_ready) begin @(negedge clk); #1; end
        blk_end = 1'b1;
        exp_q.push_back(TERM); tag_q.push_back(tag);
        @(negedge clk); #1;
        blk_end = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R9 cf_ready after reset", 32'(cf_ready), 32'd1);

        // R1: run/level pairs with signed levels, including extremes
        for (int r = 0; r < 20; r++) put(0, r * 13, r * 4099 - 30000, 0, 0, 0, "R1 run/level");
        put(0, 16'hFFFF, 16'h8000, 0, 0, 0, "R1 min level");
        put(0, 1, 16'h7FFF, 0, 0, 0, "R1 max level");
        end_block("R5 terminator after R1 block");

        // R2/R3/R4: every DC size with junk above the size
        for (int s = 0; s <= 11; s++) begin
            put(1, 0, 0, s, 11'h7FF, 0, "R3 DC all ones");
            put(1, 0, 0, s, 11'h555 ^ (s * 37), 0, "R2/R3 DC pattern");
            put(1, 0, 0, s, 11'h400 | 1, 0, "R4 DC low zero fill");
            put(0, s, -s, 0, 0, 0, "R1 after DC");
            end_block("R5 terminator after DC block");
        end
        drain();

        // R6: empty blocks
        end_block("R6 empty block");
        end_block("R6 second empty block");
        drain();

        // R5: block end in the same cycle as the last coefficient
        put(1, 0, 0, 5, 11'h13, 0, "R3 DC before same-cycle end");
        put(0, 7, -3, 0, 0, 1, "R1 last coef");
        put(0, 2, 9, 0, 0, 0, "R5 coef after terminator");
        drain();

        // R7/R8: sink held off
        sink_mode = 2;
        put(0, 42, -42, 0, 0, 0, "R7 held word");
        repeat (2) @(negedge clk);
        #1;
        chk("R8 cf_ready low while slot held", 32'(cf_ready), 32'd0);
        chk("R7 out_valid held", 32'(out_valid), 32'd1);
        chk("R7 out_word held", out_word, {16'd42, 16'hFFD6});
        repeat (3) @(negedge clk);
        #1;
        chk("R7 out_word still held", out_word, {16'd42, 16'hFFD6});
        sink_mode = 0;
        drain();

        // R8: terminator pending blocks intake
        sink_mode = 2;
        put(0, 3, 3, 0, 0, 1, "R7 word ahead of pending end");
        @(negedge clk); #1;
        chk("R8 cf_ready low while terminator pending", 32'(cf_ready), 32'd0);
        sink_mode = 0;
        drain();

        // R7: random back-pressure, mixed traffic
        sink_mode = 1;
        for (int b = 0; b < 30; b++) begin
            put(1, 0, 0, b % 12, b * 91, 0, "R7 DC under back-pressure");
            for (int k = 0; k < (b % 4); k++) put(0, b + k, 500 - b * k, 0, 0, 0, "R7 pair under back-pressure");
            if (b % 5 == 0) end_block("R7 terminator under back-pressure");
            else put(0, b, b, 0, 0, 1, "R7 pair with end");
            if (b % 7 == 0) end_block("R6 empty under back-pressure");
        end
        drain();
        sink_mode = 0;
        repeat (4) @(negedge clk); #1;
        chk("R7 idle after drain", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule